// File: doc/BRIEF.md
# Two-Variable Spiking Neuron Step Engine

This block keeps the state of a single spiking neuron and moves it forward by one time step each time a tick strobe is accepted. The state has two signed fixed-point variables. The fast one, a membrane potential, grows quadratically. The slow one, a recovery term, pulls the potential back. Four programmable coefficients set the behaviour. One gives the recovery rate and one the coupling from potential to recovery. The other two give the potential after a spike and the amount added to recovery after a spike. A signed input current is supplied for each step.

A step runs over five clock cycles and uses one shared saturating multiplier. The sequencer moves through the states S_IDLE, S_SQ (square the potential), S_SCALE (scale the square by 0.04), S_BV (coupling times potential), S_AR (rate times the recovery error) and S_COMMIT (write the new state). Its transitions are as follows. S_IDLE goes to S_SQ on an accepted tick. The states then advance unconditionally S_SQ→S_SCALE→S_BV→S_AR→S_COMMIT. S_COMMIT returns to S_IDLE. Both derivatives are formed from the potential and recovery held before the step. The result is a forward-Euler update with unit time step. The only event output is a one-cycle spike flag, and the cycle in which it rises marks the step that fired.

Top module: `izh_neuron`

## Requirements
- R1: While `rst` is high at a clock edge, the potential is loaded with `prm_c` and the recovery with rnd(`prm_b`·`prm_c`). At the same edge `spike`, `busy` and `overrun` are cleared. All values are signed with W=32 bits and F=16 fractional bits. rnd(x·y) is defined as (x·y + 2^(F−1)) arithmetically shifted right by F and then saturated.
- R2: A high `tick` at an edge while in S_IDLE starts a step. `busy` is high for exactly the five cycles after that edge and is low otherwise.
- R3: The new potential is v' = sat(v + sat(k·rnd(v·v) rounded + 5v + 140 − u + I)), where k = 2621 (0.04 in the format). The inner sum is saturated once.
- R4: The new recovery is u' = sat(u + rnd(a·sat(rnd(b·v) − u))).
- R5: Both derivatives use the potential and recovery from before the step. `v_out` and `u_out` change only at the fifth edge after the accepting edge, where both change together.
- R6: If v' is strictly greater than 30, the potential becomes c and the recovery becomes sat(u' + d). Otherwise v' and u' are stored.
- R7: `spike` is high for exactly one cycle, the cycle in which the updated state first appears, and only when R6 fired.
- R8: A `tick` that is high at an edge while `busy` is high is ignored. It sets `overrun`, which stays high until reset.
- R9: `i_cur`, `prm_a`, `prm_b`, `prm_c` and `prm_d` are sampled at the accepting edge. Changes to them during a step do not affect that step.
- R10: Every product and sum saturates to the W-bit signed range [−2^(W−1), 2^(W−1)−1] and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Step request strobe |
| i_cur | input | W | Input current for the step, signed fixed point |
| prm_a | input | W | Recovery rate |
| prm_b | input | W | Recovery coupling to potential |
| prm_c | input | W | Potential after a spike |
| prm_d | input | W | Recovery increment after a spike |
| v_out | output | W | Membrane potential |
| u_out | output | W | Recovery variable |
| spike | output | 1 | One-cycle fire flag |
| busy | output | 1 | Step in progress |
| overrun | output | 1 | Sticky: tick arrived while busy |

## Verification
The bench builds the block with its defaults, W=32 and F=16. This leaves a 16-bit integer part. With that range, a current of −32000 drives the square and the potential sum past the format limits in two steps, so every saturation path is reached. A regular-spiking parameter set with a moderate current produces repeated spikes and resets. A held-high tick tests back-to-back acceptance at the first idle edge. Ticks and parameter changes during a step test the overrun flag and input sampling.

// File: rtl/izh_pkg.sv
package izh_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SQ,
        S_SCALE,
        S_BV,
        S_AR,
        S_COMMIT
    } izh_state_e;

endpackage

// File: rtl/izh_fxmul.sv
module izh_fxmul #(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] y,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] MAXV = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (F - 1);

    logic signed [PW-1:0] xe, ye, full, rnd, shf;

    always_comb begin
        xe   = {{W{x[W-1]}}, x};
        ye   = {{W{y[W-1]}}, y};
        full = xe * ye;
        rnd  = full + HALF;
        shf  = rnd >>> F;
        if (shf > MAXV)
            p = MAXV[W-1:0];
        else if (shf < MINV)
            p = MINV[W-1:0];
        else
            p = shf[W-1:0];
    end

endmodule

// File: rtl/izh_update.sv
module izh_update #(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic signed [W-1:0] v,
    input  logic signed [W-1:0] u,
    input  logic signed [W-1:0] i_cur,
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] d,
    input  logic signed [W-1:0] q,
    input  logic signed [W-1:0] s,
    output logic signed [W-1:0] v_next,
    output logic signed [W-1:0] u_next,
    output logic                fire
);
    localparam int XW = W + 4;
    localparam logic signed [XW-1:0] K140 = XW'(140) <<< F;
    localparam logic signed [W-1:0]  THR  = W'(30) <<< F;
    localparam logic signed [XW-1:0] MAXV = {{5{1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {{5{1'b1}}, {(W-1){1'b0}}};

    function automatic logic signed [XW-1:0] ext(input logic signed [W-1:0] z);
        return {{4{z[W-1]}}, z};
    endfunction

    function automatic logic signed [W-1:0] clampw(input logic signed [XW-1:0] z);
        if (z > MAXV)      return MAXV[W-1:0];
        else if (z < MINV) return MINV[W-1:0];
        else               return z[W-1:0];
    endfunction

    logic signed [W-1:0] dv, vn, un;

    always_comb begin
        dv     = clampw(ext(q) + (ext(v) <<< 2) + ext(v) + K140 - ext(u) + ext(i_cur));
        vn     = clampw(ext(v) + ext(dv));
        un     = clampw(ext(u) + ext(s));
        fire   = (vn > THR);
        v_next = fire ? c : vn;
        u_next = fire ? clampw(ext(un) + ext(d)) : un;
    end

endmodule

// File: rtl/izh_seq.sv
module izh_seq
    import izh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    output izh_state_e state,
    output logic       busy,
    output logic       accept,
    output logic       overrun
);
    izh_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = tick ? S_SQ : S_IDLE;
            S_SQ:     nxt = S_SCALE;
            S_SCALE:  nxt = S_BV;
            S_BV:     nxt = S_AR;
            S_AR:     nxt = S_COMMIT;
            S_COMMIT: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state != S_IDLE);
        accept = (state == S_IDLE) && tick;
    end

    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (tick && busy)
            overrun <= 1'b1;
    end

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !busy) |=> busy);

    assert_commit_to_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_COMMIT) |=> !busy);

endmodule

// File: rtl/izh_neuron.sv
module izh_neuron
    import izh_pkg::*;
#(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic signed [W-1:0] i_cur,
    input  logic signed [W-1:0] prm_a,
    input  logic signed [W-1:0] prm_b,
    input  logic signed [W-1:0] prm_c,
    input  logic signed [W-1:0] prm_d,
    output logic signed [W-1:0] v_out,
    output logic signed [W-1:0] u_out,
    output logic                spike,
    output logic                busy,
    output logic                overrun
);
    localparam int XW   = W + 4;
    localparam int K004 = ((4 << F) + 50) / 100;
    localparam logic signed [XW-1:0] MAXV = {{5{1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {{5{1'b1}}, {(W-1){1'b0}}};

    izh_state_e state;
    logic       accept;

    logic signed [W-1:0] v_q, u_q;
    logic signed [W-1:0] sn_i, sn_a, sn_b, sn_c, sn_d;
    logic signed [W-1:0] p_q, q_q, r_q, s_q;
    logic signed [W-1:0] mx, my, mp, err;
    logic signed [W-1:0] v_next, u_next;
    logic                fire, spike_q;

    izh_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .state   (state),
        .busy    (busy),
        .accept  (accept),
        .overrun (overrun)
    );

    izh_fxmul #(.W(W), .F(F)) u_mul (
        .x (mx),
        .y (my),
        .p (mp)
    );

    izh_update #(.W(W), .F(F)) u_upd (
        .v      (v_q),
        .u      (u_q),
        .i_cur  (sn_i),
        .c      (sn_c),
        .d      (sn_d),
        .q      (q_q),
        .s      (s_q),
        .v_next (v_next),
        .u_next (u_next),
        .fire   (fire)
    );

    // recovery error b*v - u, saturated before the rate multiply
    always_comb begin
        logic signed [XW-1:0] diff;
        diff = {{4{r_q[W-1]}}, r_q} - {{4{u_q[W-1]}}, u_q};
        if (diff > MAXV)      err = MAXV[W-1:0];
        else if (diff < MINV) err = MINV[W-1:0];
        else                  err = diff[W-1:0];
    end

    // shared multiplier operand select
    always_comb begin
        mx = '0;
        my = '0;
        if (rst) begin
            mx = prm_b;
            my = prm_c;
        end else begin
            unique case (state)
                S_IDLE:   begin mx = '0;       my = '0;  end
                S_SQ:     begin mx = v_q;      my = v_q; end
                S_SCALE:  begin mx = W'(K004); my = p_q; end
                S_BV:     begin mx = sn_b;     my = v_q; end
                S_AR:     begin mx = sn_a;     my = err; end
                S_COMMIT: begin mx = '0;       my = '0;  end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q     <= prm_c;
            u_q     <= mp;
            spike_q <= 1'b0;
            sn_i    <= '0;
            sn_a    <= '0;
            sn_b    <= '0;
            sn_c    <= '0;
            sn_d    <= '0;
            p_q     <= '0;
            q_q     <= '0;
            r_q     <= '0;
            s_q     <= '0;
        end else begin
            spike_q <= 1'b0;
            if (accept) begin
                sn_i <= i_cur;
                sn_a <= prm_a;
                sn_b <= prm_b;
                sn_c <= prm_c;
                sn_d <= prm_d;
            end
            unique case (state)
                S_IDLE:   ;
                S_SQ:     p_q <= mp;
                S_SCALE:  q_q <= mp;
                S_BV:     r_q <= mp;
                S_AR:     s_q <= mp;
                S_COMMIT: begin
                    v_q     <= v_next;
                    u_q     <= u_next;
                    spike_q <= fire;
                end
            endcase
        end
    end

    assign v_out = v_q;
    assign u_out = u_q;
    assign spike = spike_q;

    assert_state_held_R5: assert property (@(posedge clk) disable iff (rst)
        (state != S_COMMIT) |=> ($stable(v_q) && $stable(u_q)));

    assert_spike_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        spike |=> !spike);

    assert_spike_idle_R7: assert property (@(posedge clk) disable iff (rst)
        spike |-> !busy);

    assert_spike_from_commit_R7: assert property (@(posedge clk) disable iff (rst)
        spike |-> ($past(state) == S_COMMIT));

endmodule

// File: tb/izh_neuron_tb_top.sv
module izh_neuron_tb_top;
    localparam int W = 32;
    localparam longint ONE = 65536;
    localparam longint VMAX = 64'sd2147483647;
    localparam longint VMIN = -64'sd2147483648;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic signed [W-1:0] i_cur, prm_a, prm_b, prm_c, prm_d;
    logic signed [W-1:0] v_out, u_out;
    logic spike, busy, overrun;

    int n_checks = 0;
    int n_err = 0;
    int n_spikes = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    izh_neuron dut_i (
        .clk(clk), .rst(rst), .tick(tick), .i_cur(i_cur),
        .prm_a(prm_a), .prm_b(prm_b), .prm_c(prm_c), .prm_d(prm_d),
        .v_out(v_out), .u_out(u_out), .spike(spike), .busy(busy), .overrun(overrun)
    );

    function automatic longint sat(input longint z);
        if (z > VMAX) return VMAX;
        if (z < VMIN) return VMIN;
        return z;
    endfunction

    function automatic longint mulq(input longint x, input longint y);
        return sat((x * y + 32768) >>> 16);
    endfunction

    // reference model
    longint mv, mu, ki, ka, kb, kc, kd;
    int     remain = 0;
    bit     mspk = 0, movr = 0;

    always @(posedge clk) begin
        if (rst) begin
            mv = prm_c; mu = mulq(prm_b, prm_c);
            remain = 0; mspk = 0; movr = 0;
        end else begin
            mspk = 0;
            if (remain == 0) begin
                if (tick) begin
                    ki = i_cur; ka = prm_a; kb = prm_b; kc = prm_c; kd = prm_d;
                    remain = 5;
                end
            end else begin
                if (tick) movr = 1;
                remain--;
                if (remain == 0) begin
                    longint dv, vn, un;
                    dv = sat(mulq(2621, mulq(mv, mv)) + 5 * mv + 140 * ONE - mu + ki);
                    vn = sat(mv + dv);
                    un = sat(mu + mulq(ka, sat(mulq(kb, mv) - mu)));
                    if (vn > 30 * ONE) begin
                        mv = kc; mu = sat(un + kd); mspk = 1;
                    end else begin
                        mv = vn; mu = un;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        chk("R3 v_out", longint'(v_out), mv);
        chk("R4 u_out", longint'(u_out), mu);
        chk("R7 spike", longint'(spike), longint'(mspk));
        chk("R2 busy", longint'(busy), longint'(remain != 0));
        chk("R8 overrun", longint'(overrun), longint'(movr));
        if (spike) n_spikes++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_once;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        cyc(6);
    endtask

    task automatic regular_params;
        prm_a = 32'sd1311; prm_b = 32'sd13107;
        prm_c = -32'sd65 * 32'sd65536; prm_d = 32'sd8 * 32'sd65536;
    endtask

    initial begin
        regular_params();
        i_cur = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 v after reset", longint'(v_out), -65 * ONE);
        chk("R1 u after reset", longint'(u_out), mulq(13107, -65 * ONE));
        chk("R1 busy after reset", longint'(busy), 0);
        chk("R1 overrun after reset", longint'(overrun), 0);

        // R6 repeated spiking with moderate current
        i_cur = 32'sd10 * 32'sd65536;
        for (int k = 0; k < 60; k++) step_once();
        chk("R6 spikes produced", longint'(n_spikes > 0), 1);

        // R9 and R5: change inputs while busy
        begin
            longint v0, u0;
            v0 = v_out; u0 = u_out;
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            i_cur = 32'sd900 * 32'sd65536; prm_a = 32'sd60000; prm_b = -32'sd40000;
            prm_c = 32'sd5 * 32'sd65536; prm_d = -32'sd3 * 32'sd65536;
            for (int k = 0; k < 4; k++) begin
                chk("R5 v held during step", longint'(v_out), v0);
                chk("R5 u held during step", longint'(u_out), u0);
                cyc(1);
            end
            cyc(3);
            chk("R9 v uses sampled inputs", longint'(v_out), mv);
            regular_params();
            i_cur = 32'sd10 * 32'sd65536;
        end

        // R8 ticks during busy, including the commit cycle
        chk("R8 overrun clear before", longint'(overrun), 0);
        @(negedge clk); tick = 1'b1;
        cyc(6);
        tick = 1'b0;
        cyc(1);
        chk("R8 overrun set", longint'(overrun), 1);
        cyc(6);

        // R2 back-to-back acceptance with tick held high
        tick = 1'b1;
        cyc(36);
        tick = 1'b0;
        cyc(7);
        chk("R8 overrun still set", longint'(overrun), 1);

        // R10 saturation with a large negative current
        i_cur = -32'sd32000 * 32'sd65536;
        for (int k = 0; k < 4; k++) step_once();
        chk("R10 v saturates low", longint'(v_out), VMIN);

        // reset with another parameter set
        prm_c = -32'sd50 * 32'sd65536; prm_b = 32'sd16384;
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        chk("R1 v after second reset", longint'(v_out), -50 * ONE);
        chk("R1 u after second reset", longint'(u_out), mulq(16384, -50 * ONE));
        chk("R1 overrun cleared", longint'(overrun), 0);

        // R6 immediate fire with a large positive current
        n_spikes = 0;
        i_cur = 32'sd20000 * 32'sd65536;
        for (int k = 0; k < 3; k++) step_once();
        chk("R6 fire on large current", longint'(n_spikes), 3);
        chk("R6 v back at c", longint'(v_out), -50 * ONE);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule